// File: doc/BRIEF.md
# Preamble-Gated Sync Field Deserializer

This block pulls one record out of a serial disk bit stream whose bit clock has already been recovered. Each recovered bit arrives as a one-cycle valid strobe with its value. A start request latches the record length in words. The block then disregards every incoming bit for a fixed preamble interval, measured in word times. Only after that does it begin hunting for sync. Sync is a run of zero bits long enough to be trusted, closed by a single one bit.

Once synced, the block gathers 16-bit words with the first bit received as the most significant. It emits each data word with a strobe and its position in the record. It folds every data word into a running XOR checksum that starts from a seed. It takes one further word as the stored checksum and compares the two. It then raises a one-cycle done pulse with the comparison result and drops back to the unsynchronized idle state. If sync is not found within a bounded number of word times after the preamble, the record ends with an error flag and no words are emitted. A controller calls the block once per record, for example for a short header, a medium label and a long data field.

Top module: `syncFieldReader`

## Requirements
- R1: After reset, busy, synced, wordValid, done, chkOk and syncErr are all low.
- R2: For PREAMBLE_WORDS*WORD_CYC clock cycles after an accepted start, bit strobes have no effect. A zero run and a one bit seen in that window neither cause sync nor shift any bit into a word.
- R3: After the preamble, a one bit completes sync only if at least MIN_ZEROS zero bits came directly before it. A run of exactly MIN_ZEROS zeros is enough.
- R4: A one bit that arrives after fewer than MIN_ZEROS zeros does not sync, leaves synced low, and restarts the zero count from nothing.
- R5: After sync, bits are packed into 16-bit words with the first received bit at bit 15. Exactly wordCount data words are emitted, each with a one-cycle wordValid pulse. wordIndex counts 0, 1, 2 and upward, and wordCount may be any value from 1 to MAX_WORDS.
- R6: The word after the data words is the stored checksum. done pulses for one cycle, and chkOk is high exactly when the stored word equals SEED XOR every data word.
- R7: When done pulses, synced and busy are already low, and later bits have no effect until the next start.
- R8: If TIMEOUT_WORDS*WORD_CYC cycles pass in the hunt phase without sync, done pulses with syncErr high and chkOk low, no word is emitted, and the done pulse is visible PREAMBLE_WORDS*WORD_CYC + TIMEOUT_WORDS*WORD_CYC + 1 cycles after the cycle in which start was driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a record; accepted only while idle |
| wordCount | input | 9 | Number of data words in the record, latched at start |
| bitValid | input | 1 | One-cycle strobe marking a recovered bit |
| bitVal | input | 1 | Value of the recovered bit |
| busy | output | 1 | A record is in progress |
| synced | output | 1 | Sync found; words are being assembled |
| wordValid | output | 1 | One-cycle strobe for an emitted data word |
| wordData | output | 16 | Assembled data word |
| wordIndex | output | 8 | Position of the word in the record |
| done | output | 1 | One-cycle end-of-record pulse |
| chkOk | output | 1 | Stored checksum matched; held until the next start |
| syncErr | output | 1 | Record ended by sync timeout; held until the next start |

## Verification
The bench places a complete fake sync pattern inside the preamble. A block that listened too early would lock onto it, and every later word would come out shifted. One record leads with a zero run that is too short and ends in a one. A design that kept the earlier zeros counted, or that accepted the one, would sync early and misalign the data. Another record uses exactly the minimum run, which catches an off-by-one threshold. A corrupted stored checksum must clear chkOk, and a stream with no bits at all must end by timeout on the exact expected cycle.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_PREAMBLE = 2'd1,
    ST_HUNT     = 2'd2,
    ST_DATA     = 2'd3
  } sfrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadRec;
    logic shiftEn;
    logic failSync;
  } sfrStrobe_t;

endpackage

// File: rtl/sfr_ctrl.sv
module sfr_ctrl
  import sfr_pkg::*;
#(
  parameter int WORD_CYC       = 192,
  parameter int PREAMBLE_WORDS = 21,
  parameter int MIN_ZEROS      = 32,
  parameter int TIMEOUT_WORDS  = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       bitValid,
  input  logic       bitVal,
  input  logic       wordDone,
  input  logic       lastWord,
  output sfrStrobe_t strobe,
  output logic       busy,
  output logic       synced
);

  localparam int PRE_CYC = PREAMBLE_WORDS * WORD_CYC;
  localparam int TO_CYC  = TIMEOUT_WORDS * WORD_CYC;
  localparam int MAX_CYC = (PRE_CYC > TO_CYC) ? PRE_CYC : TO_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int ZC_W    = $clog2(MIN_ZEROS + 1);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_CYC - 1);
  localparam logic [CNT_W-1:0] TO_LAST  = CNT_W'(TO_CYC - 1);
  localparam logic [ZC_W-1:0]  ZC_MIN   = ZC_W'(MIN_ZEROS);

  sfrState_t        state;
  logic [CNT_W-1:0] cycCnt;
  logic [ZC_W-1:0]  zeroCnt;
  logic             syncHit;
  logic             huntExpire;

  assign syncHit    = (state == ST_HUNT) && bitValid && bitVal && (zeroCnt >= ZC_MIN);
  assign huntExpire = (state == ST_HUNT) && (cycCnt == TO_LAST) && !syncHit;

  always_comb begin
    strobe          = '0;
    strobe.loadRec  = (state == ST_IDLE) && start;
    strobe.shiftEn  = (state == ST_DATA) && bitValid;
    strobe.failSync = huntExpire;
  end

  assign busy   = (state != ST_IDLE);
  assign synced = (state == ST_DATA);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cycCnt  <= '0;
      zeroCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_PREAMBLE;
            cycCnt <= '0;
          end
        end
        ST_PREAMBLE: begin
          if (cycCnt == PRE_LAST) begin
            state   <= ST_HUNT;
            cycCnt  <= '0;
            zeroCnt <= '0;
          end else begin
            cycCnt <= cycCnt + 1'b1;
          end
        end
        ST_HUNT: begin
          if (syncHit) begin
            state <= ST_DATA;
          end else if (huntExpire) begin
            state <= ST_IDLE;
          end else begin
            cycCnt <= cycCnt + 1'b1;
            if (bitValid) begin
              if (bitVal)                zeroCnt <= '0;
              else if (zeroCnt != ZC_MIN) zeroCnt <= zeroCnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (wordDone && lastWord) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sfr_datapath.sv
module sfr_datapath
  import sfr_pkg::*;
#(
  parameter int          WORD_W    = 16,
  parameter int          MAX_WORDS = 256,
  parameter logic [15:0] SEED      = 16'h0151
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  sfrStrobe_t                     strobe,
  input  logic                           bitVal,
  input  logic [$clog2(MAX_WORDS+1)-1:0] recWords,
  output logic                           wordDone,
  output logic                           lastWord,
  output logic                           wordValid,
  output logic [WORD_W-1:0]              wordData,
  output logic [$clog2(MAX_WORDS)-1:0]   wordIndex,
  output logic                           done,
  output logic                           chkOk,
  output logic                           syncErr
);

  localparam int BIT_W = $clog2(WORD_W);
  localparam int LEN_W = $clog2(MAX_WORDS + 1);
  localparam int IDX_W = $clog2(MAX_WORDS);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] assembled;
  logic [BIT_W-1:0]  bitCnt;
  logic [LEN_W-1:0]  wordIdx;
  logic [LEN_W-1:0]  recLen;
  logic [WORD_W-1:0] checksum;

  assign assembled = {shiftReg[WORD_W-2:0], bitVal};
  assign wordDone  = strobe.shiftEn && (bitCnt == BIT_LAST);
  assign lastWord  = (wordIdx == recLen);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      bitCnt    <= '0;
      wordIdx   <= '0;
      recLen    <= '0;
      checksum  <= '0;
      wordValid <= 1'b0;
      wordData  <= '0;
      wordIndex <= '0;
      done      <= 1'b0;
      chkOk     <= 1'b0;
      syncErr   <= 1'b0;
    end else begin
      wordValid <= 1'b0;
      done      <= 1'b0;
      if (strobe.loadRec) begin
        recLen   <= recWords;
        wordIdx  <= '0;
        bitCnt   <= '0;
        checksum <= WORD_W'(SEED);
        chkOk    <= 1'b0;
        syncErr  <= 1'b0;
      end
      if (strobe.shiftEn) begin
        shiftReg <= assembled;
        bitCnt   <= wordDone ? '0 : bitCnt + 1'b1;
        if (wordDone) begin
          if (!lastWord) begin
            wordValid <= 1'b1;
            wordData  <= assembled;
            wordIndex <= wordIdx[IDX_W-1:0];
            checksum  <= checksum ^ assembled;
            wordIdx   <= wordIdx + 1'b1;
          end else begin
            done  <= 1'b1;
            chkOk <= (checksum == assembled);
          end
        end
      end
      if (strobe.failSync) begin
        done    <= 1'b1;
        syncErr <= 1'b1;
        chkOk   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/syncFieldReader.sv
module syncFieldReader
  import sfr_pkg::*;
#(
  parameter int          WORD_CYC       = 192,
  parameter int          PREAMBLE_WORDS = 21,
  parameter int          MIN_ZEROS      = 32,
  parameter int          TIMEOUT_WORDS  = 40,
  parameter int          MAX_WORDS      = 256,
  parameter logic [15:0] SEED           = 16'h0151
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           start,
  input  logic [$clog2(MAX_WORDS+1)-1:0] wordCount,
  input  logic                           bitValid,
  input  logic                           bitVal,
  output logic                           busy,
  output logic                           synced,
  output logic                           wordValid,
  output logic [15:0]                    wordData,
  output logic [$clog2(MAX_WORDS)-1:0]   wordIndex,
  output logic                           done,
  output logic                           chkOk,
  output logic                           syncErr
);

  sfrStrobe_t strobe;
  logic       wordDone;
  logic       lastWord;

  sfr_ctrl #(
    .WORD_CYC      (WORD_CYC),
    .PREAMBLE_WORDS(PREAMBLE_WORDS),
    .MIN_ZEROS     (MIN_ZEROS),
    .TIMEOUT_WORDS (TIMEOUT_WORDS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .bitValid(bitValid),
    .bitVal  (bitVal),
    .wordDone(wordDone),
    .lastWord(lastWord),
    .strobe  (strobe),
    .busy    (busy),
    .synced  (synced)
  );

  sfr_datapath #(
    .WORD_W   (16),
    .MAX_WORDS(MAX_WORDS),
    .SEED     (SEED)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .bitVal   (bitVal),
    .recWords (wordCount),
    .wordDone (wordDone),
    .lastWord (lastWord),
    .wordValid(wordValid),
    .wordData (wordData),
    .wordIndex(wordIndex),
    .done     (done),
    .chkOk    (chkOk),
    .syncErr  (syncErr)
  );

endmodule

// File: rtl/sfr_checker.sv
module sfr_checker #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             synced,
  input logic             wordValid,
  input logic [IDX_W-1:0] wordIndex,
  input logic             done,
  input logic             chkOk,
  input logic             syncErr
);

  AST_IDLE_NOT_SYNCED: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !synced); // R1
  AST_SYNC_NEEDS_RECORD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(synced) |-> $past(busy)); // R3
  AST_WORD_WHILE_SYNCED: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> $past(synced)); // R5
  AST_INDEX_STEPS: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && wordIndex != '0) |-> $past(synced)); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6
  AST_DONE_DROPS_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!synced && !busy)); // R7
  AST_ERR_NOT_OK: assert property (@(posedge clk) disable iff (!rstN)
    syncErr |-> !chkOk); // R8
  AST_ERR_NO_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    (done && syncErr) |-> !$past(synced)); // R8

endmodule

bind syncFieldReader sfr_checker #(.IDX_W($clog2(MAX_WORDS))) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (busy),
  .synced   (synced),
  .wordValid(wordValid),
  .wordIndex(wordIndex),
  .done     (done),
  .chkOk    (chkOk),
  .syncErr  (syncErr)
);

// File: tb/syncFieldReader_tb.sv
module syncFieldReader_tb;

  localparam int WORD_CYC = 16;
  localparam int PRE_W    = 21;
  localparam int MIN_Z    = 16;
  localparam int TO_W     = 40;
  localparam int MAXW     = 256;
  localparam logic [15:0] SEED = 16'h0151;
  localparam int PRE_CYC  = PRE_W * WORD_CYC;
  localparam int TO_CYC   = TO_W * WORD_CYC;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [8:0]  wordCount = '0;
  logic        bitValid = 1'b0;
  logic        bitVal = 1'b0;
  logic        busy, synced, wordValid, done, chkOk, syncErr;
  logic [15:0] wordData;
  logic [7:0]  wordIndex;

  always #5 clk = ~clk;

  syncFieldReader #(
    .WORD_CYC(WORD_CYC), .PREAMBLE_WORDS(PRE_W), .MIN_ZEROS(MIN_Z),
    .TIMEOUT_WORDS(TO_W), .MAX_WORDS(MAXW), .SEED(SEED)
  ) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .wordCount(wordCount),
    .bitValid(bitValid), .bitVal(bitVal), .busy(busy), .synced(synced),
    .wordValid(wordValid), .wordData(wordData), .wordIndex(wordIndex),
    .done(done), .chkOk(chkOk), .syncErr(syncErr)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  int cycle = 0;

  logic [15:0] txWords [MAXW];
  logic [15:0] rxWords [MAXW];
  int rxCount, idxBad, doneCount, doneCycle;
  logic gotOk, gotErr;

  always @(posedge clk) cycle <= cycle + 1;

  always @(negedge clk) begin
    if (wordValid) begin
      if (int'(wordIndex) != rxCount) idxBad++;
      if (rxCount < MAXW) rxWords[rxCount] = wordData;
      rxCount++;
    end
    if (done) begin
      doneCount++;
      doneCycle = cycle;
      gotOk  = chkOk;
      gotErr = syncErr;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clearMon();
    rxCount = 0; idxBad = 0; doneCount = 0; doneCycle = 0;
    gotOk = 1'b0; gotErr = 1'b0;
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk); bitValid = 1'b1; bitVal = b;
    @(negedge clk); bitValid = 1'b0; bitVal = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendWord(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) sendBit(w[i]);
  endtask

  task automatic startRec(input int n, output int c0);
    @(negedge clk); start = 1'b1; wordCount = 9'(n); c0 = cycle;
    @(negedge clk); start = 1'b0;
  endtask

  // one full record; mode 0 plain, 1 spurious bits in preamble, 2 short zero run first
  task automatic runRecord(input string tag, input int n, input int mode,
                           input bit badChk, input logic [15:0] salt);
    int c0;
    logic [15:0] sum;
    clearMon();
    sum = SEED;
    for (int i = 0; i < n; i++) begin
      txWords[i] = 16'(salt ^ (i * 16'h2b3d) ^ (16'h8001 >> (i % 16)));
      sum = sum ^ txWords[i];
    end
    startRec(n, c0);
    if (mode == 1) begin
      // R2: complete fake sync inside the preamble, then junk
      for (int i = 0; i < MIN_Z + 4; i++) sendBit(1'b0);
      sendBit(1'b1);
      sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
      check(synced == 1'b0, {tag, " R2 no sync in preamble"}, synced, 0);
    end
    while (cycle < c0 + PRE_CYC + 3) @(negedge clk);
    if (mode == 2) begin
      for (int i = 0; i < 5; i++) sendBit(1'b0);
      sendBit(1'b1);
      check(synced == 1'b0, {tag, " R4 short run rejected"}, synced, 0);
      for (int i = 0; i < MIN_Z - 6; i++) sendBit(1'b0);
      sendBit(1'b1);
      check(synced == 1'b0, {tag, " R4 zero count restarted"}, synced, 0);
    end
    for (int i = 0; i < MIN_Z; i++) sendBit(1'b0);
    sendBit(1'b1);
    check(synced == 1'b1, {tag, " R3 sync after exact minimum run"}, synced, 1);
    for (int i = 0; i < n; i++) sendWord(txWords[i]);
    sendWord(badChk ? ~sum : sum);
    repeat (4) @(negedge clk);
    check(doneCount == 1, {tag, " R6 one done pulse"}, doneCount, 1);
    check(gotOk == !badChk, {tag, " R6 checksum verdict"}, gotOk, !badChk);
    check(gotErr == 1'b0, {tag, " R8 no sync error"}, gotErr, 0);
    check(rxCount == n, {tag, " R5 word count"}, rxCount, n);
    check(idxBad == 0, {tag, " R5 word index order"}, idxBad, 0);
    for (int i = 0; i < n && i < rxCount; i++)
      if (rxWords[i] != txWords[i]) begin
        check(1'b0, {tag, " R5 word data MSB first"}, rxWords[i], txWords[i]);
        break;
      end
    check(!synced && !busy, {tag, " R7 back to unsynced idle"}, {synced, busy}, 0);
    // R7: bits after done are ignored
    sendBit(1'b0); sendBit(1'b1);
    check(rxCount == n && doneCount == 1 && !synced, {tag, " R7 bits after done ignored"},
          rxCount, n);
  endtask

  task automatic testReset();
    check(!busy && !synced && !wordValid, "R1 idle after reset", {busy, synced, wordValid}, 0);
    check(!done && !chkOk && !syncErr, "R1 flags low after reset", {done, chkOk, syncErr}, 0);
  endtask

  task automatic testTimeout();
    int c0;
    clearMon();
    startRec(4, c0);
    while (cycle < c0 + PRE_CYC + TO_CYC + 8) @(negedge clk);
    check(doneCount == 1, "R8 timeout done pulse", doneCount, 1);
    check(gotErr == 1'b1 && gotOk == 1'b0, "R8 error flag set, ok clear", {gotErr, gotOk}, 2);
    check(rxCount == 0, "R8 no words emitted", rxCount, 0);
    check(doneCycle == c0 + 1 + PRE_CYC + TO_CYC, "R8 timeout cycle", doneCycle,
          c0 + 1 + PRE_CYC + TO_CYC);
    check(!busy, "R7 idle after timeout", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    runRecord("header", 2, 0, 1'b0, 16'h0000);
    runRecord("label", 8, 1, 1'b0, 16'h3c5a);
    runRecord("shortrun", 3, 2, 1'b0, 16'h9e17);
    runRecord("badsum", 5, 0, 1'b1, 16'h7421);
    testTimeout();
    runRecord("data", 256, 0, 1'b0, 16'hc0de);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule